// File: doc/BRIEF.md
# Two-Wire Register Slave with Time Snapshot

This block is a target on a two-wire serial bus (START/STOP framing, 7-bit address, ninth-clock acknowledge) that gives a bus master byte access to a small register space. The bus address is fixed at binary 1101000. After its address with a write direction, the first byte a master sends loads an internal register pointer. Each later byte is written at that pointer, and the pointer then advances. A read transfer returns bytes starting at the pointer and continues while the master acknowledges.

The lowest addresses hold the time-of-day counters that another block keeps running. They are read from a snapshot. The snapshot is retaken from the live counter input on every START, every STOP, and every time the pointer steps around to address zero, so a multibyte read never sees a counter roll over part way through. Every accepted write byte is presented as a one-cycle strobe with its address and data during the acknowledge clock, so the counter block can load new time values. The upper addresses are stored in this block and read back.

Both bus lines are sampled by a fast system clock. SDA is driven only low, with an output-enable style pin. The block does not stretch the clock and does not answer the general-call address.

Top module: `twi_reg_slave`

## Requirements
- R1: A START (SDA falling while SCL is high) or a repeated START ends any activity and prepares the block to receive an address byte. A STOP (SDA rising while SCL is high) returns it to idle.
- R2: The block acknowledges an address byte whose upper seven bits are 1101000 by holding SDA low through the ninth clock. The eighth bit selects the direction: 0 for write, 1 for read. Bits are sent MSB first.
- R3: In a write transfer, the first byte after the address loads its low 4 bits into the pointer. Every later byte is acknowledged and written at the pointer, which then increments.
- R4: A read transfer returns the byte at the current pointer. This is the last stored pointer value when no pointer byte came first. The pointer increments after each byte, and sending continues while the master acknowledges.
- R5: The pointer wraps from address 15 to address 0 in both reads and writes.
- R6: Reads of addresses 0 to 6 return byte i of the time input (bits 8i+7..8i) as captured at the most recent START, STOP, or pointer step to address 0. Later changes to the input are not visible until the next such event.
- R7: Each accepted write byte produces exactly one `wr_stb_o` pulse, with `wr_addr_o` and `wr_data_o`, while SCL is high in the acknowledge clock and SDA is held low by the block.
- R8: After the master does not acknowledge a read byte, the block releases SDA and drives nothing until the next START or STOP.
- R9: For an address byte that does not match, the block does not acknowledge. It then acknowledges nothing, writes nothing and leaves the pointer unchanged until the next START.
- R10: SDA is only pulled low. It changes only while SCL is low, except for being released at a START or STOP, and it is released after reset.
- R11: Addresses 7 to 15 read back the last value written to them and read as 0x00 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 20 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |
| time_i | input | 56 | Live time counters, byte i for address i |
| wr_stb_o | output | 1 | One-cycle pulse for an accepted write byte |
| wr_addr_o | output | 4 | Address of the write byte |
| wr_data_o | output | 8 | Value of the write byte |

## Verification
On every cycle, the assertions check four properties: SDA changes only while SCL is low or at a START/STOP, a write strobe occurs only while the block is acknowledging, the pointer steps from 15 to 0, and a snapshot event copies the live time input exactly. They also check that the block stays silent after a foreign address and that every START leaves it ready for an address. The scenarios are the only way to show that whole transfers deliver the right bytes in the right order. These cover a read that resumes from a stored pointer, a snapshot that stays frozen while the live counters move during a read and is then retaken at the wrap to zero, and bus traffic after a foreign address that leaves the pointer unchanged.

// File: rtl/twi_pkg.sv
package twi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_SKIP
  } twi_state_e;

  typedef enum logic [1:0] {
    RL_ADDR,
    RL_PTR,
    RL_DATA
  } twi_role_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] scl_q, sda_q;
  logic         scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[MSB-1:0], scl_i};
      sda_q <= {sda_q[MSB-1:0], sda_i};
      scl_d <= scl_q[MSB];
      sda_d <= sda_q[MSB];
    end
  end

  assign scl_s     = scl_q[MSB];
  assign sda_s     = sda_q[MSB];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/twi_regbank.sv
module twi_regbank #(
  parameter int AW    = 4,
  parameter int DW    = 8,
  parameter int NTIME = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              refresh,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [AW-1:0]     rd_addr,
  input  logic [NTIME*DW-1:0] time_i,
  output logic [DW-1:0]     rd_data
);
  localparam int NREGS = 1 << AW;

  logic [NTIME*DW-1:0] shadow_q;
  logic [DW-1:0]       word [NREGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
    end else if (refresh) begin
      shadow_q <= time_i;
    end
  end

  for (genvar i = 0; i < NREGS; i++) begin : g_word
    if (i < NTIME) begin : g_time
      assign word[i] = shadow_q[i*DW +: DW];
    end else begin : g_store
      logic [DW-1:0] reg_q;
      logic          we;
      assign we = wr_en && (wr_addr == AW'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          reg_q <= '0;
        end else if (we) begin
          reg_q <= wr_data;
        end
      end
      assign word[i] = reg_q;
    end
  end

  assign rd_data = word[rd_addr];

  AST_SHADOW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |=> (shadow_q == $past(time_i))); // R6
endmodule

// File: rtl/twi_engine.sv
module twi_engine
  import twi_pkg::*;
#(
  parameter int         AW       = 4,
  parameter int         DW       = 8,
  parameter logic [6:0] DEV_ADDR = 7'h68
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [DW-1:0] rd_data,
  output logic          sda_oe,
  output logic [AW-1:0] ptr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          refresh
);
  localparam logic [AW-1:0] PTR_TOP = {AW{1'b1}};
  localparam int            CW      = $clog2(DW + 1);
  localparam logic [CW-1:0] BITS    = CW'(DW);
  localparam logic [CW-1:0] LASTBIT = CW'(DW - 1);

  twi_state_e    state_q, state_d;
  twi_role_e     role_q, role_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] sh_q, sh_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic          rw_q, rw_d;
  logic          oe_q, oe_d;
  logic          mack_q, mack_d;

  always_comb begin
    state_d = state_q;
    role_d  = role_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    ptr_d   = ptr_q;
    rw_d    = rw_q;
    oe_d    = oe_q;
    mack_d  = mack_q;
    wr_en   = 1'b0;
    refresh = 1'b0;
    if (start_det) begin
      state_d = ST_RX;
      role_d  = RL_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
      refresh = 1'b1;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
      refresh = 1'b1;
    end else begin
      case (state_q)
        ST_RX: begin
          if (scl_rise && cnt_q != BITS) begin
            sh_d  = {sh_q[DW-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == BITS) begin
            if (role_q == RL_ADDR && sh_q[DW-1:DW-7] != DEV_ADDR) begin
              state_d = ST_SKIP;
            end else begin
              state_d = ST_RX_ACK;
              oe_d    = 1'b1;
              if (role_q == RL_ADDR) rw_d = sh_q[0];
            end
          end
        end
        ST_RX_ACK: begin
          if (scl_rise) begin
            if (role_q == RL_DATA) begin
              wr_en   = 1'b1;
              ptr_d   = ptr_q + 1'b1;
              refresh = (ptr_q == PTR_TOP);
            end else if (role_q == RL_PTR) begin
              ptr_d = sh_q[AW-1:0];
            end
          end else if (scl_fall) begin
            cnt_d = '0;
            if (role_q == RL_ADDR && rw_q) begin
              state_d = ST_TX;
              sh_d    = rd_data;
              oe_d    = ~rd_data[DW-1];
            end else begin
              state_d = ST_RX;
              role_d  = (role_q == RL_ADDR) ? RL_PTR : RL_DATA;
              oe_d    = 1'b0;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == LASTBIT) begin
              state_d = ST_TX_ACK;
              oe_d    = 1'b0;
            end else begin
              sh_d  = {sh_q[DW-2:0], 1'b0};
              oe_d  = ~sh_q[DW-2];
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            mack_d  = ~sda_s;
            ptr_d   = ptr_q + 1'b1;
            refresh = (ptr_q == PTR_TOP);
          end else if (scl_fall) begin
            if (mack_q) begin
              state_d = ST_TX;
              sh_d    = rd_data;
              oe_d    = ~rd_data[DW-1];
              cnt_d   = '0;
            end else begin
              state_d = ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      role_q  <= RL_ADDR;
      cnt_q   <= '0;
      sh_q    <= '0;
      ptr_q   <= '0;
      rw_q    <= 1'b0;
      oe_q    <= 1'b0;
      mack_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      role_q  <= role_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      ptr_q   <= ptr_d;
      rw_q    <= rw_d;
      oe_q    <= oe_d;
      mack_q  <= mack_d;
    end
  end

  assign sda_oe  = oe_q;
  assign ptr     = ptr_q;
  assign wr_addr = ptr_q;
  assign wr_data = sh_q;

  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state_q == ST_RX && cnt_q == '0 && !oe_q)); // R1
  AST_SDA_CHANGE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q != $past(oe_q)) |-> (!$past(scl_s) || $past(start_det) || $past(stop_det))); // R10
  AST_WRITE_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> oe_q); // R7
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ptr_q == PTR_TOP) |=> (ptr_q == '0)); // R5
  AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SKIP) |-> !oe_q); // R9
endmodule

// File: rtl/twi_reg_slave.sv
module twi_reg_slave #(
  parameter int         AW          = 4,
  parameter int         DW          = 8,
  parameter int         NTIME       = 7,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'h68
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_oe_o,
  input  logic [NTIME*DW-1:0] time_i,
  output logic                wr_stb_o,
  output logic [AW-1:0]       wr_addr_o,
  output logic [DW-1:0]       wr_data_o
);
  logic [1:0]    rst_pipe;
  logic          sys_rst_n;
  logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic          refresh, wr_en;
  logic [AW-1:0] ptr, wr_addr;
  logic [DW-1:0] wr_data, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign sys_rst_n = rst_pipe[1];

  twi_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(sys_rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  twi_engine #(.AW(AW), .DW(DW), .DEV_ADDR(DEV_ADDR)) u_engine (
    .clk(clk), .rst_n(sys_rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .rd_data(rd_data), .sda_oe(sda_oe_o), .ptr(ptr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .refresh(refresh)
  );

  twi_regbank #(.AW(AW), .DW(DW), .NTIME(NTIME)) u_bank (
    .clk(clk), .rst_n(sys_rst_n), .refresh(refresh), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(ptr), .time_i(time_i),
    .rd_data(rd_data)
  );

  assign wr_stb_o  = wr_en;
  assign wr_addr_o = wr_addr;
  assign wr_data_o = wr_data;
endmodule

// File: tb/tb_twi_reg_slave.sv
`timescale 1ns/1ps
module tb_twi_reg_slave;
  localparam int Q = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        scl_m, sda_m;
  logic        sda_oe_o, wr_stb_o;
  logic [55:0] time_v;
  logic [3:0]  wr_addr_o;
  logic [7:0]  wr_data_o;
  logic        sda_line;

  int n_chk = 0;
  int n_err = 0;

  logic [7:0]  exp_rd_q[$];
  string       exp_rd_tag[$];
  logic [7:0]  obs_rd_q[$];
  logic [11:0] exp_wr_q[$];

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe_o;

  twi_reg_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe_o), .time_i(time_v), .wr_stb_o(wr_stb_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_io(input logic b, output logic s);
    wait_clk(Q);
    sda_m = b;
    wait_clk(Q);
    scl_m = 1'b1;
    wait_clk(Q);
    s = sda_line;
    wait_clk(Q);
    scl_m = 1'b0;
  endtask

  task automatic do_start();
    wait_clk(Q);
    sda_m = 1'b1;
    wait_clk(Q);
    scl_m = 1'b1;
    wait_clk(Q);
    sda_m = 1'b0;
    wait_clk(Q);
    scl_m = 1'b0;
  endtask

  task automatic do_stop();
    wait_clk(Q);
    sda_m = 1'b0;
    wait_clk(Q);
    scl_m = 1'b1;
    wait_clk(Q);
    sda_m = 1'b1;
    wait_clk(2*Q);
  endtask

  task automatic wr_byte(input logic [7:0] v, input int exp_ack, input string req);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(v[i], s);
    bit_io(1'b1, s);
    chk(req, s ? 0 : 1, exp_ack);
  endtask

  task automatic expect_wr(input logic [3:0] a, input logic [7:0] d);
    exp_wr_q.push_back({a, d});
  endtask

  task automatic rd_byte(input logic [7:0] exp, input string req, input logic ack_it);
    logic s;
    logic [7:0] v;
    exp_rd_q.push_back(exp);
    exp_rd_tag.push_back(req);
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, s);
      v[i] = s;
    end
    bit_io(!ack_it, s);
    obs_rd_q.push_back(v);
  endtask

  // read monitor: compares produced bytes against expected queue
  always @(negedge clk) begin
    while (obs_rd_q.size() > 0) begin
      logic [7:0] o, e;
      string t;
      o = obs_rd_q.pop_front();
      if (exp_rd_q.size() == 0) begin
        chk("R4 unexpected read", o, 0);
      end else begin
        e = exp_rd_q.pop_front();
        t = exp_rd_tag.pop_front();
        chk(t, o, e);
      end
    end
  end

  // write-strobe monitor (R7)
  always @(negedge clk) begin
    if (rst_n && wr_stb_o) begin
      if (exp_wr_q.size() == 0) begin
        chk("R9/R7 unexpected write strobe", {wr_addr_o, wr_data_o}, 0);
      end else begin
        logic [11:0] e;
        e = exp_wr_q.pop_front();
        chk("R7 write addr/data", {wr_addr_o, wr_data_o}, e);
        chk("R7 strobe while SCL high", scl_m, 1);
        chk("R7 strobe while SDA acked low", sda_line, 0);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  localparam logic [55:0] T1 = 56'h07_06_05_04_03_02_01;
  localparam logic [55:0] T2 = 56'h17_16_15_14_13_12_11;
  localparam logic [55:0] T3 = 56'h27_26_25_24_23_22_21;
  localparam logic [7:0]  AW_WR = 8'hD0;
  localparam logic [7:0]  AW_RD = 8'hD1;

  initial begin
    logic s;
    rst_n  = 1'b0;
    scl_m  = 1'b1;
    sda_m  = 1'b1;
    time_v = T1;
    wait_clk(5);
    chk("R10 reset release", sda_oe_o, 0);
    chk("R7 reset no strobe", wr_stb_o, 0);
    rst_n = 1'b1;
    wait_clk(10);

    // R2/R3: pointer then four data bytes at 8..11
    do_start();
    wr_byte(AW_WR, 1, "R2 write address ack");
    wr_byte(8'h08, 1, "R3 pointer ack");
    expect_wr(4'd8,  8'h11); wr_byte(8'h11, 1, "R3 data ack");
    expect_wr(4'd9,  8'h22); wr_byte(8'h22, 1, "R3 data ack");
    expect_wr(4'd10, 8'h33); wr_byte(8'h33, 1, "R3 data ack");
    expect_wr(4'd11, 8'h44); wr_byte(8'h44, 1, "R3 data ack");
    do_stop();

    // R11: unwritten register reads zero; R8 release after nack
    do_start();
    wr_byte(AW_RD, 1, "R2 read address ack");
    rd_byte(8'h00, "R11 reset value of reg 12", 1'b0);
    bit_io(1'b1, s);
    chk("R8 SDA released after nack", s, 1);
    chk("R8 no drive after nack", sda_oe_o, 0);
    do_stop();

    // R1/R4: pointer write, repeated start, sequential read
    do_start();
    wr_byte(AW_WR, 1, "R2 write address ack");
    wr_byte(8'h08, 1, "R3 pointer ack");
    do_start();
    wr_byte(AW_RD, 1, "R1 address ack after repeated start");
    rd_byte(8'h11, "R4 read reg 8", 1'b1);
    rd_byte(8'h22, "R4 read reg 9", 1'b1);
    rd_byte(8'h33, "R4 read reg 10", 1'b0);
    do_stop();

    // R4: read resumes from stored pointer (11)
    do_start();
    wr_byte(AW_RD, 1, "R2 read address ack");
    rd_byte(8'h44, "R4 resume at stored pointer", 1'b0);
    do_stop();

    // R9: foreign address ignored, pointer unchanged (12)
    do_start();
    wr_byte(8'hD2, 0, "R9 foreign address nack");
    wr_byte(8'h0C, 0, "R9 later byte not acked");
    wr_byte(8'h5A, 0, "R9 later byte not acked");
    do_stop();
    do_start();
    wr_byte(AW_RD, 1, "R2 read address ack");
    rd_byte(8'h00, "R9 pointer unchanged by foreign transfer", 1'b0);
    do_stop();

    // R5: write wraps 15 -> 0
    do_start();
    wr_byte(AW_WR, 1, "R2 write address ack");
    wr_byte(8'h0F, 1, "R3 pointer ack");
    expect_wr(4'd15, 8'hA5); wr_byte(8'hA5, 1, "R5 data ack at 15");
    expect_wr(4'd0,  8'h3C); wr_byte(8'h3C, 1, "R5 data ack after wrap");
    do_stop();

    // R6: snapshot frozen during read
    time_v = T1;
    do_start();
    wr_byte(AW_WR, 1, "R2 write address ack");
    wr_byte(8'h00, 1, "R3 pointer ack");
    do_start();
    wr_byte(AW_RD, 1, "R1 address ack after repeated start");
    time_v = T2;
    for (int i = 0; i < 7; i++)
      rd_byte(T1[8*i +: 8], "R6 snapshot byte frozen", (i != 6));
    do_stop();

    // R6/R5: snapshot retaken when read pointer wraps to 0
    do_start();
    wr_byte(AW_WR, 1, "R2 write address ack");
    wr_byte(8'h0E, 1, "R3 pointer ack");
    do_start();
    wr_byte(AW_RD, 1, "R1 address ack after repeated start");
    time_v = T3;
    rd_byte(8'h00, "R11 reg 14 reset value", 1'b1);
    rd_byte(8'hA5, "R11 reg 15 written value", 1'b1);
    rd_byte(T3[7:0], "R6 snapshot retaken at wrap", 1'b0);
    do_stop();

    // R6: STOP retook T3; fresh start reads time byte 1 of T3
    do_start();
    wr_byte(AW_WR, 1, "R2 write address ack");
    wr_byte(8'h01, 1, "R3 pointer ack");
    do_start();
    wr_byte(AW_RD, 1, "R1 address ack after repeated start");
    rd_byte(T3[15:8], "R6 snapshot after start", 1'b0);
    do_stop();

    wait_clk(20);
    chk("R3 all expected writes seen", exp_wr_q.size(), 0);
    chk("R4 all expected reads seen", exp_rd_q.size(), 0);
    finish_run();
  end
endmodule